// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A prescaler divides the timebase clock (32.768 kHz by default) into a once-per-second advance. The prescaler also drives a 1 Hz square output whose low-to-high edge falls half a second into each second. Hours can be kept in either 24-hour or 12-hour form. The choice is made by a bit inside the hours byte itself.

A byte-wide port, addressed by an auto-incrementing pointer, gives access to the seven bytes. Writes go straight to the live counters. A write to the seconds byte also restarts the prescaler. Reads never touch the live counters. They are served from a snapshot that is reloaded on a bus start, a bus stop, or the pointer wrapping back to byte 0. A multi-byte read therefore sees one instant in time, even if a second boundary passes during the transfer.

Byte map (pointer value: content): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month with the century flag in bit 7, 6 year.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Passing 59 gives 00 and carries into the next field.
- R2: With hours bit 6 clear (24-hour form), bits 5:0 hold BCD 00..23. Hour 23 followed by a carry gives 00 and advances the day.
- R3: With hours bit 6 set (12-hour form), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 01..12. The sequence is 11 -> 12 with PM toggled, and 12 -> 01 with PM kept. Only 11 PM -> 12 AM advances the day.
- R4: The day-of-week byte (bits 2:0) advances on each day carry, and 7 wraps to 1.
- R5: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days, and the other months other than February have 31. February has 29 days when the two-digit year is a multiple of 4, and 28 otherwise.
- R6: The month (bits 4:0, BCD) wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and toggles month bit 7 (century).
- R7: A write stores the byte at the pointer into the live counter, and the pointer then advances; pointer 6 advances to 0. The stored bits are masked as follows:
  - 7F for seconds, minutes and hours
  - 07 for day of week
  - 3F for date
  - 9F for month
  - FF for year
- R8: A write to byte 0 restarts the prescaler. `tick_1hz` is low for the next TICK_DIV/2 timebase cycles and high for the TICK_DIV/2 after that. The seconds advance exactly TICK_DIV cycles after the write.
- R9: `rdata` shows the snapshot byte at the pointer. The snapshot reloads from the live counters on `bus_start`, on `bus_stop` and on a pointer wrap from 6 to 0. It holds otherwise, while the live time moves on.
- R10: While `osc_off` is high, neither the prescaler nor any time field advances, and `tick_1hz` holds its level.
- R11: After reset the time reads 00:00:00 in 24-hour form, with day of week 1, date 01, month 01, century 0, year 00, and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (TICK_DIV cycles per second) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_off | input | 1 | High stops the prescaler and all counting |
| bus_start | input | 1 | One-cycle pulse marking a bus start; reloads the snapshot |
| bus_stop | input | 1 | One-cycle pulse marking a bus stop; reloads the snapshot |
| ptr_set | input | 1 | Loads the pointer from ptr_val |
| ptr_val | input | 3 | New pointer value (values above 6 load 0) |
| wr_en | input | 1 | Write wdata at the pointer, then advance the pointer |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Byte consumed; advance the pointer |
| rdata | output | 8 | Snapshot byte at the pointer |
| tick_1hz | output | 1 | 1 Hz square output, high in the second half of each second |

## Verification
A wrong carry in any field shows up as a wrong byte in the first read that spans the affected boundary. That read comes one second after the preceding second boundary, so the sweeps place each start point just before a month, year, hour or 12-hour boundary and advance a single second. A prescaler phase error shows on `tick_1hz` within TICK_DIV/2 cycles of a seconds write, and as a seconds byte one count off at the next read. A snapshot that reloads at the wrong moment returns a time newer or older than the last start, stop or wrap by whole seconds. The bench separates the three reload causes by running the clock between them.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

   localparam int unsigned NREG = 7;
   localparam int unsigned PW   = 3;

   typedef enum logic [PW-1:0] {
      A_SEC   = 3'd0,
      A_MIN   = 3'd1,
      A_HOUR  = 3'd2,
      A_DOW   = 3'd3,
      A_DATE  = 3'd4,
      A_MONTH = 3'd5,
      A_YEAR  = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } cal_t;

   localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                  dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic year_is_leap(input logic [7:0] y);
      logic [6:0] s;
      s = {2'b00, y[7:4], 1'b0} + {3'b000, y[3:0]};
      return s[1:0] == 2'b00;
   endfunction

   function automatic logic [7:0] month_len(input logic [4:0] m, input logic [7:0] y);
      case (m)
         5'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] wr_mask(input logic [PW-1:0] a);
      case (a)
         A_DOW:   return 8'h07;
         A_DATE:  return 8'h3F;
         A_MONTH: return 8'h9F;
         A_YEAR:  return 8'hFF;
         default: return 8'h7F;
      endcase
   endfunction

   function automatic logic [7:0] cal_byte(input cal_t c, input int unsigned idx);
      case (idx)
         0:       return c.sec;
         1:       return c.min;
         2:       return c.hour;
         3:       return c.dow;
         4:       return c.date;
         5:       return c.month;
         default: return c.year;
      endcase
   endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick,
   output logic half_hi
);
   localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int unsigned HALF = DIV / 2;
   localparam bit          POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("rtcc_prescaler: DIV must be even and at least 2");
      end
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (restart) cnt_q <= '0;
            else if (run)     cnt_q <= cnt_q + 1'b1;
         end
         assign tick    = run && !restart && (&cnt_q);
         assign half_hi = cnt_q[CW-1];
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (restart)                 cnt_q <= '0;
            else if (run && cnt_q == CW'(DIV - 1)) cnt_q <= '0;
            else if (run)                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick    = run && !restart && (cnt_q == CW'(DIV - 1));
         assign half_hi = (cnt_q >= CW'(HALF));
      end
   endgenerate

   AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !half_hi); // R8
   AST_TICK_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !half_hi); // R8
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(half_hi)); // R10

endmodule

// File: rtl/rtcc_counter.sv
module rtcc_counter
   import rtcc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_addr,
   input  logic [7:0]    wdata,
   output cal_t          live
);
   cal_t       nx;
   logic       c_min, c_hr, c_day, c_mon, c_yr;
   logic [7:0] t_hr, t_dt, t_mo, mlen;

   always_comb begin
      nx    = live;
      c_min = 1'b0;
      c_hr  = 1'b0;
      c_day = 1'b0;
      c_mon = 1'b0;
      c_yr  = 1'b0;
      t_hr  = '0;
      t_dt  = bcd_inc({2'b00, live.date[5:0]});
      t_mo  = bcd_inc({3'b000, live.month[4:0]});
      mlen  = month_len(live.month[4:0], live.year);
      if (tick) begin
         if (live.sec[6:0] == 7'h59) begin
            nx.sec = 8'h00;
            c_min  = 1'b1;
         end else begin
            nx.sec = bcd_inc(live.sec);
         end
         if (c_min) begin
            if (live.min[6:0] == 7'h59) begin
               nx.min = 8'h00;
               c_hr   = 1'b1;
            end else begin
               nx.min = bcd_inc(live.min);
            end
         end
         if (c_hr) begin
            if (live.hour[6]) begin
               t_hr = bcd_inc({3'b000, live.hour[4:0]});
               case (live.hour[4:0])
                  5'h11: begin
                     nx.hour = {2'b01, ~live.hour[5], 5'h12};
                     c_day   = live.hour[5];
                  end
                  5'h12:   nx.hour = {2'b01, live.hour[5], 5'h01};
                  default: nx.hour = {2'b01, live.hour[5], t_hr[4:0]};
               endcase
            end else begin
               t_hr = bcd_inc({2'b00, live.hour[5:0]});
               if (live.hour[5:0] == 6'h23) begin
                  nx.hour = 8'h00;
                  c_day   = 1'b1;
               end else begin
                  nx.hour = {2'b00, t_hr[5:0]};
               end
            end
         end
         if (c_day) begin
            nx.dow = (live.dow[2:0] >= 3'd7) ? 8'h01 : {5'b0, live.dow[2:0] + 3'd1};
            if (live.date[5:0] == mlen[5:0]) begin
               nx.date = 8'h01;
               c_mon   = 1'b1;
            end else begin
               nx.date = {2'b00, t_dt[5:0]};
            end
         end
         if (c_mon) begin
            if (live.month[4:0] == 5'h12) begin
               nx.month = {live.month[7], 7'h01};
               c_yr     = 1'b1;
            end else begin
               nx.month = {live.month[7], 2'b00, t_mo[4:0]};
            end
         end
         if (c_yr) begin
            if (live.year == 8'h99) begin
               nx.year     = 8'h00;
               nx.month[7] = ~live.month[7];
            end else begin
               nx.year = bcd_inc(live.year);
            end
         end
      end
      if (wr_en) begin
         case (wr_addr)
            A_SEC:   nx.sec   = wdata & wr_mask(A_SEC);
            A_MIN:   nx.min   = wdata & wr_mask(A_MIN);
            A_HOUR:  nx.hour  = wdata & wr_mask(A_HOUR);
            A_DOW:   nx.dow   = wdata & wr_mask(A_DOW);
            A_DATE:  nx.date  = wdata & wr_mask(A_DATE);
            A_MONTH: nx.month = wdata & wr_mask(A_MONTH);
            default: nx.year  = wdata & wr_mask(A_YEAR);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= CAL_RESET;
      else        live <= nx;
   end

   AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en) |=> (live.sec != $past(live.sec))); // R1
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> (live == $past(live))); // R10
   AST_CENTURY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && (live.month[7] != $past(live.month[7])))
         |-> ($past(live.year) == 8'h99 && live.year == 8'h00)); // R6
   AST_DAY_ONLY_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && (live.dow != $past(live.dow)))
         |-> (live.sec == 8'h00 && live.min == 8'h00)); // R4

endmodule

// File: rtl/rtcc_pointer.sv
module rtcc_pointer
   import rtcc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_set,
   input  logic [PW-1:0] ptr_val,
   input  logic          step,
   output logic [PW-1:0] ptr,
   output logic          wrap
);
   localparam logic [PW-1:0] LAST = PW'(NREG - 1);

   assign wrap = step && !ptr_set && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (ptr_set) ptr <= (ptr_val > LAST) ? '0 : ptr_val;
      else if (wrap)    ptr <= '0;
      else if (step)    ptr <= ptr + 1'b1;
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ptr_set && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R7
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (ptr == '0)); // R7

endmodule

// File: rtl/rtcc_shadow.sv
module rtcc_shadow
   import rtcc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  cal_t          live,
   input  logic [PW-1:0] ptr,
   output logic [7:0]    rdata
);
   logic [7:0] live_b [NREG];
   logic [7:0] sh_q   [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_byte
         assign live_b[g] = cal_byte(live, g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sh_q[g] <= cal_byte(CAL_RESET, g);
            else if (cap) sh_q[g] <= live_b[g];
         end
         AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !cap |=> $stable(sh_q[g])); // R9
         AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            cap |=> (sh_q[g] == $past(live_b[g]))); // R9
      end
   endgenerate

   assign rdata = (ptr < PW'(NREG)) ? sh_q[ptr] : 8'h00;

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
   import rtcc_pkg::*;
#(
   parameter int unsigned TICK_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_off,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       ptr_set,
   input  logic [2:0] ptr_val,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       rd_en,
   output logic [7:0] rdata,
   output logic       tick_1hz
);
   logic          tick, restart, wrap, cap;
   logic [PW-1:0] ptr;
   cal_t          live;

   generate
      if (TICK_DIV < 2 || (TICK_DIV % 2) != 0) begin : g_bad_div
         $error("bcd_calendar_rtc: TICK_DIV must be even and at least 2");
      end
   endgenerate

   assign restart = wr_en && !ptr_set && (ptr == A_SEC);
   assign cap     = bus_start || bus_stop || wrap;

   rtcc_prescaler #(.DIV(TICK_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!osc_off),
      .restart (restart),
      .tick    (tick),
      .half_hi (tick_1hz)
   );

   rtcc_pointer u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_set (ptr_set),
      .ptr_val (ptr_val),
      .step    ((rd_en || wr_en) && !ptr_set),
      .ptr     (ptr),
      .wrap    (wrap)
   );

   rtcc_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en && !ptr_set),
      .wr_addr (ptr),
      .wdata   (wdata),
      .live    (live)
   );

   rtcc_shadow u_shd (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .live  (live),
      .ptr   (ptr),
      .rdata (rdata)
   );

   AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off |-> !tick); // R10

endmodule

// File: tb/sim_bcd_calendar_rtc.sv
`timescale 1ns/1ps
module sim_bcd_calendar_rtc;
   localparam int DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_off = 1'b1;
   logic       bus_start = 1'b0, bus_stop = 1'b0, ptr_set = 1'b0;
   logic [2:0] ptr_val = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tick_1hz;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   // model state (binary)
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cent;
   bit m_12;

   always #4 clk = ~clk;

   bcd_calendar_rtc #(.TICK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_off(osc_off), .bus_start(bus_start),
      .bus_stop(bus_stop), .ptr_set(ptr_set), .ptr_val(ptr_val), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .tick_1hz(tick_1hz));

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mdays(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] enc(input int i);
      int h;
      case (i)
         0: return bcd(m_sec);
         1: return bcd(m_min);
         2: begin
            if (!m_12) return bcd(m_hr);
            h = (m_hr % 12 == 0) ? 12 : m_hr % 12;
            return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | bcd(h);
         end
         3: return 8'(m_dow);
         4: return bcd(m_date);
         5: return 8'(m_cent << 7) | bcd(m_mon);
         default: return bcd(m_yr);
      endcase
   endfunction

   task automatic adv(input int n);
      for (int k = 0; k < n; k++) begin
         m_sec++;
         if (m_sec == 60) begin m_sec = 0; m_min++; end
         if (m_min == 60) begin m_min = 0; m_hr++; end
         if (m_hr == 24) begin
            m_hr = 0;
            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
            m_date++;
            if (m_date > mdays(m_mon, m_yr)) begin m_date = 1; m_mon++; end
            if (m_mon == 13) begin m_mon = 1; m_yr++; end
            if (m_yr == 100) begin m_yr = 0; m_cent ^= 1; end
         end
      end
   endtask

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input int idx);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s byte %0d: actual %02h expected %02h", req, idx, got, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic got, input logic exp, input int k);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s tick_1hz at step %0d: actual %0b expected %0b", req, k, got, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic set_ptr(input int a);
      ptr_set = 1'b1; ptr_val = 3'(a);
      @(negedge clk);
      ptr_set = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] v);
      wr_en = 1'b1; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_model();
      set_ptr(0);
      for (int i = 0; i < 7; i++) wr_byte(enc(i));
   endtask

   task automatic run_secs(input int n);
      osc_off = 1'b0;
      repeat (DIV * n) @(posedge clk);
      @(negedge clk);
      osc_off = 1'b1;
   endtask

   task automatic read_model(input string req, input bit with_start);
      if (with_start) bus_start = 1'b1;
      ptr_set = 1'b1; ptr_val = 3'd0;
      @(negedge clk);
      bus_start = 1'b0; ptr_set = 1'b0;
      for (int i = 0; i < 7; i++) begin
         chk(req, rdata, enc(i), i);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
   endtask

   task automatic pulse_stop();
      bus_stop = 1'b1;
      @(negedge clk);
      bus_stop = 1'b0;
   endtask

   task automatic pulse_start();
      bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
   endtask

   task automatic set_time(input int h, input int mi, input int s, input int dw,
                           input int dt, input int mo, input int yr, input int ce, input bit h12);
      m_hr = h; m_min = mi; m_sec = s; m_dow = dw; m_date = dt;
      m_mon = mo; m_yr = yr; m_cent = ce; m_12 = h12;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int yrs [4];
      yrs[0] = 23; yrs[1] = 24; yrs[2] = 99; yrs[3] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state through the snapshot
      set_time(0, 0, 0, 1, 1, 1, 0, 0, 0);
      read_model("R11", 1);

      // R5 R6 R4 R2: month-end sweep, several years, both century values
      for (int y = 0; y < 4; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_time(23, 59, 59, 7, mdays(mo, yrs[y]), mo, yrs[y], mo % 2, 0);
            load_model();
            run_secs(1);
            adv(1);
            read_model("R5/R6/R4/R2", 1);
         end
      end
      // R5: 28 Feb in a leap and a non-leap year
      set_time(23, 59, 59, 3, 28, 2, 48, 0, 0); load_model(); run_secs(1); adv(1);
      read_model("R5", 1);
      set_time(23, 59, 59, 3, 28, 2, 50, 0, 0); load_model(); run_secs(1); adv(1);
      read_model("R5", 1);

      // R2: every 24-hour hour boundary
      for (int h = 0; h < 24; h++) begin
         set_time(h, 59, 59, 2, 15, 6, 30, 0, 0);
         load_model(); run_secs(1); adv(1);
         read_model("R2", 1);
      end
      // R3: every 12-hour boundary including 11 AM, 11 PM, 12 AM, 12 PM
      for (int h = 0; h < 24; h++) begin
         set_time(h, 59, 59, 7, 31, 12, 99, 1, 1);
         load_model(); run_secs(1); adv(1);
         read_model("R3", 1);
      end

      // R1: long run through minute and hour carries
      set_time(21, 58, 3, 5, 10, 10, 10, 0, 0);
      load_model();
      for (int k = 0; k < 40; k++) begin
         run_secs(97); adv(97);
         read_model("R1", 1);
      end

      // R7: masked writes, pointer auto-increment and wrap
      set_ptr(0);
      wr_byte(8'hD5); wr_byte(8'hA7); wr_byte(8'h95); wr_byte(8'hFB);
      wr_byte(8'hC8); wr_byte(8'h72); wr_byte(8'h47);
      wr_byte(8'h33); // wrapped back to seconds
      set_time(15, 27, 33, 3, 8, 12, 47, 0, 0);
      read_model("R7", 1);
      set_ptr(3);
      wr_byte(8'h05); wr_byte(8'h19);
      m_dow = 5; m_date = 19;
      read_model("R7", 1);

      // R8: seconds write restarts prescaler mid-count
      set_time(10, 20, 10, 4, 2, 3, 4, 0, 0);
      load_model();
      osc_off = 1'b0;
      repeat (5) @(negedge clk);
      set_ptr(0);
      wr_byte(bcd(10));
      chk_bit("R8", tick_1hz, 1'b0, 0);
      for (int k = 1; k <= DIV; k++) begin
         @(negedge clk);
         if (k == DIV) osc_off = 1'b1;
         chk_bit("R8", tick_1hz, (k >= DIV / 2 && k < DIV), k);
      end
      adv(1);
      read_model("R8", 1);

      // R10: oscillator off holds everything
      osc_off = 1'b1;
      repeat (100) @(negedge clk);
      chk_bit("R10", tick_1hz, 1'b0, 100);
      read_model("R10", 1);

      // R9: snapshot reload on start, wrap and stop only
      set_time(8, 0, 50, 6, 1, 1, 1, 0, 0);
      load_model();
      run_secs(3);
      pulse_start();
      run_secs(2);
      adv(3);
      read_model("R9", 0);     // start snapshot; wrap reloads T+5
      run_secs(1);
      adv(2);
      read_model("R9", 0);     // wrap snapshot; wrap reloads T+6
      run_secs(1);
      pulse_stop();
      adv(2);
      read_model("R9", 0);     // stop snapshot T+7

      done = 1;
      summary();
      $finish;
   end
endmodule